// File: doc/BRIEF.md
# Two-Stage System Watchdog Timer

This block is a system watchdog that software programs and services through a small register window of 32 bytes. A prescaler divides the input clock down to one tick every 0.6 s. On each tick a 10-bit down-counter loses one count. Software keeps the system alive by writing the reload register. Any write there puts the counter back to the programmed initial value and restarts the prescaler.

If the counter is allowed to run out, the block responds in two stages. On the first expiry it latches a timeout status flag, pulses an interrupt for one cycle and reloads the counter. If the counter runs out again while that flag is still set, the block latches a second-timeout flag and raises a system reset request. The reset request is not raised when the no-reboot input is high. Status flags are cleared by writing 1 to them. A boot-status flag comes up set after reset so that software can tell that a power-on has taken place.

The control flow is a three-state machine. ST_HALT means the counter and prescaler are frozen; it is the state after reset. ST_RUN means the block is counting. ST_TRIP means a reset is being requested; the counter is frozen and only a block reset leaves this state. The transitions are as follows. ST_HALT goes to ST_RUN when the control register is written with the halt bit at 0. ST_RUN goes to ST_HALT when the halt bit is written as 1. ST_RUN goes to ST_TRIP on an expiry while the timeout flag is set and no-reboot is low. ST_TRIP stays in ST_TRIP.

Top module: `sys_wdog`

## Requirements
- R1: After reset the block is halted and the count reads 4. The initial-value register (offset 0x12) reads 0x0004, status 0x04 reads 0x0000, status 0x06 reads 0x0004 (boot flag, bit 2) and control 0x08 reads 0x0800. `tmo_irq` and `rst_req` are low.
- R2: While running, the count read at offset 0x00 drops by one every DIV = CLK_HZ*6/10 clock cycles. While halted it holds.
- R3: Any write to offset 0x00 loads the count with the initial value and restarts the prescaler, so the next decrement comes a full DIV cycles after the write.
- R4: Bits [9:0] of offset 0x12 hold the initial value. Bits [15:10] are stored as written and read back unchanged.
- R5: A write to offset 0x12 whose bits [9:0] are 0 to 3 leaves the stored initial value unchanged. The upper bits are still stored.
- R6: Bit 11 of offset 0x08 is a halt control. Writing 1 stops counting and writing 0 starts it. The bit reads 1 whenever the block is not counting.
- R7: An expiry happens when a tick arrives with the count at 0. If the timeout flag (bit 3 of offset 0x04) is clear, the expiry sets that flag, drives `tmo_irq` high for exactly one cycle and reloads the count.
- R8: An expiry while the timeout flag is set sets the second-timeout flag (bit 1 of offset 0x06) and does not pulse `tmo_irq`. If `no_reboot` is low, `rst_req` rises and stays high until reset, and the count freezes.
- R9: While `no_reboot` is high, `rst_req` never rises. A second expiry still sets bit 1 of 0x06, and the count reloads and keeps running.
- R10: Writing 1 to bit 3 of 0x04, or to bit 1 or bit 2 of 0x06, clears that flag. Writing 0 leaves it unchanged. After the timeout flag is cleared, the next expiry is again handled as a first expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 5 | Byte offset in the window, used for both read and write |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data for `addr` (combinational) |
| no_reboot | input | 1 | When high, blocks the reset request |
| tmo_irq | output | 1 | One-cycle pulse on a first expiry |
| rst_req | output | 1 | System reset request, held until reset |

## Verification
On every cycle the embedded assertions check the following:
- the interrupt and the prescaler tick each last a single cycle;
- the reset request is sticky and never rises while no-reboot was high;
- the second-timeout flag rises only with the timeout flag set;
- the count holds or steps by exactly one;
- the stored initial value never drops below 4.

Only the bench scenarios show the exact cycle arithmetic of ticks and expiries, and they do so across a sweep of initial values with both settings of no-reboot. The same holds for the following:
- the prescaler restart on reload;
- freezing under halt;
- rejection of the invalid initial values 0 to 3;
- a cleared timeout flag turning the next expiry back into a first one.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    typedef enum logic [1:0] {
        ST_HALT = 2'd0,
        ST_RUN  = 2'd1,
        ST_TRIP = 2'd2
    } wdt_state_e;

    localparam int unsigned CNT_W    = 10;
    localparam int unsigned INIT_MIN = 4;

    localparam logic [4:0] OFS_COUNT = 5'h00;
    localparam logic [4:0] OFS_STS1  = 5'h04;
    localparam logic [4:0] OFS_STS2  = 5'h06;
    localparam logic [4:0] OFS_CTRL  = 5'h08;
    localparam logic [4:0] OFS_INIT  = 5'h12;

    localparam int unsigned HALT_BIT = 11;
    localparam int unsigned TMO_BIT  = 3;
    localparam int unsigned SEC_BIT  = 1;
    localparam int unsigned BOOT_BIT = 2;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int unsigned CLK_HZ = 33_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic restart,
    output logic tick
);
    localparam int unsigned DIV = (CLK_HZ / 10) * 6;
    localparam int unsigned PW  = (DIV < 4) ? 2 : $clog2(DIV);
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] ps_q;

    assign tick = en && (ps_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q <= '0;
        end else if (restart) begin
            ps_q <= '0;
        end else if (en) begin
            ps_q <= tick ? '0 : ps_q + 1'b1;
        end
    end

    // R2: the tick enable lasts exactly one cycle
    a_r2_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
    parameter int unsigned W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         dec,
    input  logic [W-1:0] init,
    input  logic [W-1:0] rst_val,
    output logic [W-1:0] cnt,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    assign cnt  = cnt_q;
    assign zero = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= rst_val;
        end else if (load) begin
            cnt_q <= init;
        end else if (dec) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // R2: without load or decrement the count holds
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !dec) |=> $stable(cnt_q));
    // R2: a decrement moves the count down by exactly one
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |=> (cnt_q == $past(cnt_q) - 1'b1));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic halt_we,
    input  logic halt_val,
    input  logic tick,
    input  logic cnt_zero,
    input  logic no_reboot,
    input  logic clr_tmo,
    input  logic clr_sec,
    input  logic clr_boot,
    output logic run,
    output logic halted,
    output logic expire,
    output logic tmo_flag,
    output logic sec_flag,
    output logic boot_flag,
    output logic irq,
    output logic rst_req
);
    wdt_state_e state_q, state_d;

    assign run    = (state_q == ST_RUN);
    assign halted = !run;
    assign expire = run && tick && cnt_zero;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT: if (halt_we && !halt_val) state_d = ST_RUN;
            ST_RUN: begin
                if (expire && tmo_flag && !no_reboot) state_d = ST_TRIP;
                else if (halt_we && halt_val)         state_d = ST_HALT;
            end
            ST_TRIP: state_d = ST_TRIP;
            default: state_d = ST_HALT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmo_flag  <= 1'b0;
            sec_flag  <= 1'b0;
            boot_flag <= 1'b1;
            irq       <= 1'b0;
            rst_req   <= 1'b0;
        end else begin
            irq     <= expire && !tmo_flag;
            rst_req <= (state_d == ST_TRIP);
            if (expire)       tmo_flag <= 1'b1;
            else if (clr_tmo) tmo_flag <= 1'b0;
            if (expire && tmo_flag) sec_flag <= 1'b1;
            else if (clr_sec)       sec_flag <= 1'b0;
            if (clr_boot) boot_flag <= 1'b0;
        end
    end

    // R7: interrupt is a single-cycle pulse
    a_r7_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R8: reset request is held once raised
    a_r8_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> rst_req);
    // R8: second-timeout flag only rises with the timeout flag set
    a_r8_sec_after_tmo: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sec_flag) |-> tmo_flag);
    // R9: no reset request while no-reboot was high
    a_r9_noreboot_block: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req) |-> !$past(no_reboot));
endmodule

// File: rtl/sys_wdog.sv
module sys_wdog
    import wdt_pkg::*;
#(
    parameter int unsigned CLK_HZ = 33_000_000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [4:0]  addr,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    input  logic        no_reboot,
    output logic        tmo_irq,
    output logic        rst_req
);
    localparam int unsigned HI_W = 16 - CNT_W;
    localparam logic [CNT_W-1:0] INIT_RST = CNT_W'(INIT_MIN);

    logic wr_count, wr_sts1, wr_sts2, wr_ctrl, wr_init;
    logic tick, run, halted, expire, cnt_zero;
    logic tmo_flag, sec_flag, boot_flag;
    logic [CNT_W-1:0] cnt, init_val_q;
    logic [HI_W-1:0]  init_hi_q;

    assign wr_count = wr_en && (addr == OFS_COUNT);
    assign wr_sts1  = wr_en && (addr == OFS_STS1);
    assign wr_sts2  = wr_en && (addr == OFS_STS2);
    assign wr_ctrl  = wr_en && (addr == OFS_CTRL);
    assign wr_init  = wr_en && (addr == OFS_INIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            init_val_q <= INIT_RST;
            init_hi_q  <= '0;
        end else if (wr_init) begin
            init_hi_q <= wr_data[15:CNT_W];
            if (wr_data[CNT_W-1:0] >= INIT_RST) init_val_q <= wr_data[CNT_W-1:0];
        end
    end

    wdt_prescaler #(.CLK_HZ(CLK_HZ)) u_presc (
        .clk(clk), .rst_n(rst_n), .en(run), .restart(wr_count), .tick(tick)
    );

    wdt_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .load(wr_count || expire),
        .dec(run && tick && !cnt_zero),
        .init(init_val_q), .rst_val(INIT_RST),
        .cnt(cnt), .zero(cnt_zero)
    );

    wdt_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .halt_we(wr_ctrl), .halt_val(wr_data[HALT_BIT]),
        .tick(tick), .cnt_zero(cnt_zero), .no_reboot(no_reboot),
        .clr_tmo(wr_sts1 && wr_data[TMO_BIT]),
        .clr_sec(wr_sts2 && wr_data[SEC_BIT]),
        .clr_boot(wr_sts2 && wr_data[BOOT_BIT]),
        .run(run), .halted(halted), .expire(expire),
        .tmo_flag(tmo_flag), .sec_flag(sec_flag), .boot_flag(boot_flag),
        .irq(tmo_irq), .rst_req(rst_req)
    );

    always_comb begin
        rd_data = '0;
        case (addr)
            OFS_COUNT: rd_data[CNT_W-1:0] = cnt;
            OFS_STS1:  rd_data[TMO_BIT] = tmo_flag;
            OFS_STS2: begin
                rd_data[SEC_BIT]  = sec_flag;
                rd_data[BOOT_BIT] = boot_flag;
            end
            OFS_CTRL:  rd_data[HALT_BIT] = halted;
            OFS_INIT:  rd_data = {init_hi_q, init_val_q};
            default:   rd_data = '0;
        endcase
    end

    // R5: the stored initial value never falls below the minimum
    a_r5_init_floor: assert property (@(posedge clk) disable iff (!rst_n)
        init_val_q >= INIT_RST);
endmodule

// File: tb/sys_wdog_tb.sv
module sys_wdog_tb;
    localparam int unsigned CLK_HZ = 10;
    localparam int DIV = CLK_HZ * 6 / 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        no_reboot = 1'b0;
    logic        tmo_irq, rst_req;

    int vectors = 0;
    int fails = 0;
    int pos = 0;

    always #10 clk = ~clk;

    sys_wdog #(.CLK_HZ(CLK_HZ)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .no_reboot(no_reboot),
        .tmo_irq(tmo_irq), .rst_req(rst_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
        pos++;
    endtask

    task automatic rd(input logic [4:0] a, output int v);
        addr = a;
        #1;
        v = int'(rd_data);
    endtask

    task automatic wait_to(input int p);
        while (pos < p) begin
            @(negedge clk);
            pos++;
        end
    endtask

    task automatic do_reset(input logic nr);
        rst_n = 1'b0; no_reboot = nr; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        pos = 0;
    endtask

    task automatic start_run(input int n);
        wr(5'h12, 16'(n));
        wr(5'h00, 16'h0);
        wr(5'h08, 16'h0);
        pos = 0;
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog: run hung, got 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        int v, x1, x2, base;
        @(negedge clk);

        // R1: reset state
        do_reset(1'b0);
        rd(5'h00, v); chk("R1 count", v, 4);
        rd(5'h12, v); chk("R1 init", v, 16'h0004);
        rd(5'h04, v); chk("R1 sts1", v, 0);
        rd(5'h06, v); chk("R1 sts2", v, 16'h0004);
        rd(5'h08, v); chk("R1 ctrl", v, 16'h0800);
        chk("R1 irq", tmo_irq, 0);
        chk("R1 rst_req", rst_req, 0);
        wait_to(3 * DIV);
        rd(5'h00, v); chk("R2 halted holds", v, 4);

        // R5 / R4: invalid initial values, upper bits
        for (int k = 0; k < 4; k++) begin
            wr(5'h12, 16'hFC00 | 16'(k));
            rd(5'h12, v); chk("R5 reject low init", v, 16'hFC04);
        end
        wr(5'h12, 16'hA80C);
        rd(5'h12, v); chk("R4 init write", v, 16'hA80C);
        wr(5'h12, 16'h0003);
        rd(5'h12, v); chk("R5 field kept upper cleared", v, 16'h000C);

        // R2 / R7 / R8 / R9: sweep of initial values, both no-reboot settings
        for (int n = 4; n <= 12; n++) begin
            logic nr;
            nr = n[0];
            do_reset(nr);
            start_run(n);
            rd(5'h08, v); chk("R6 ctrl running", v, 0);
            for (int k = 0; k <= n; k++) begin
                wait_to(k * DIV + 3);
                rd(5'h00, v); chk("R2 count", v, n - k);
            end
            x1 = (n + 1) * DIV;
            wait_to(x1 - 1);
            chk("R7 no early irq", tmo_irq, 0);
            wait_to(x1);
            chk("R7 irq", tmo_irq, 1);
            rd(5'h00, v); chk("R7 reload", v, n);
            rd(5'h04, v); chk("R7 tmo flag", v, 16'h0008);
            wait_to(x1 + 1);
            chk("R7 irq one cycle", tmo_irq, 0);
            x2 = 2 * x1;
            wait_to(x2 - 1);
            chk("R8 no early rst", rst_req, 0);
            wait_to(x2);
            chk("R8 no irq on second", tmo_irq, 0);
            rd(5'h06, v); chk("R8 sec flag", v, 16'h0006);
            if (!nr) begin
                chk("R8 rst_req", rst_req, 1);
                wait_to(x2 + 2 * DIV);
                rd(5'h00, v); chk("R8 count frozen", v, n);
                chk("R8 rst held", rst_req, 1);
            end else begin
                chk("R9 rst blocked", rst_req, 0);
                wait_to(x2 + DIV);
                rd(5'h00, v); chk("R9 keeps counting", v, n - 1);
                chk("R9 rst still blocked", rst_req, 0);
            end
        end

        // R10: write-one-to-clear, first expiry again after clearing
        do_reset(1'b0);
        wr(5'h06, 16'h0000);
        rd(5'h06, v); chk("R10 write 0 keeps boot", v, 16'h0004);
        wr(5'h06, 16'h0004);
        rd(5'h06, v); chk("R10 boot cleared", v, 0);
        start_run(4);
        x1 = 5 * DIV;
        wait_to(x1);
        chk("R10 first irq", tmo_irq, 1);
        wr(5'h04, 16'h0000);
        rd(5'h04, v); chk("R10 write 0 keeps tmo", v, 16'h0008);
        wr(5'h04, 16'h0008);
        rd(5'h04, v); chk("R10 tmo cleared", v, 0);
        wait_to(2 * x1);
        chk("R10 irq again", tmo_irq, 1);
        chk("R10 no rst", rst_req, 0);
        rd(5'h06, v); chk("R10 no sec", v, 0);

        // R3: reload mid-run restarts prescaler
        do_reset(1'b0);
        start_run(8);
        wait_to(3 * DIV + 2);
        rd(5'h00, v); chk("R2 mid count", v, 5);
        wr(5'h00, 16'h1234);
        base = pos;
        rd(5'h00, v); chk("R3 reload", v, 8);
        wait_to(base + DIV - 1);
        rd(5'h00, v); chk("R3 prescaler restarted", v, 8);
        wait_to(base + DIV);
        rd(5'h00, v); chk("R3 first tick", v, 7);

        // R6: halt freezes, resume continues
        wait_to(base + 2 * DIV + 2);
        rd(5'h00, v); chk("R2 before halt", v, 6);
        wr(5'h08, 16'h0800);
        rd(5'h08, v); chk("R6 halt readback", v, 16'h0800);
        base = pos;
        wait_to(base + 4 * DIV);
        rd(5'h00, v); chk("R6 frozen", v, 6);
        chk("R6 no irq", tmo_irq, 0);
        wr(5'h08, 16'h0000);
        base = pos;
        rd(5'h00, v); chk("R6 resume", v, 6);
        wait_to(base + DIV);
        rd(5'h00, v); chk("R6 counting again", v, 5);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule